// File: doc/BRIEF.md
# Fractional-N Divide Value Update Aligner

This block sits between the programming registers and a fractional-N feedback divider whose fractional part is produced by a sigma-delta modulator. Each write of the divide-value register delivers a new integer part and a new fractional part. The block decides in which phase-detector cycle each part reaches the divider. It also produces a one-cycle reset pulse for the modulator when such a write occurs. All logic runs on the phase-detector clock.

The fractional part always passes through a pipeline of `DEPTH` phase-detector cycles. The integer part takes one of two paths, chosen per write. On the fast path it is applied at once, and the divider briefly runs at a mixed ratio (new integer, old fraction) until the fraction catches up. On the aligned path the integer part goes through a delay line of the same depth, so both parts change on the same clock edge and no transient ratio appears. Writes issued on consecutive cycles are all carried through in order. A newer integer value taken on the fast path cancels any older integer value still waiting on the aligned path, so the divider never falls back to a stale integer. A load strobe marks every edge on which the divider's operands change.

Top module: `fracn_update_aligner`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `div_int` and `div_frac` are zero and `load_stb` and `mod_rst` are low.
- R2: A write sampled on rising edge n with `wr_en` high sets `div_frac` to its `wr_frac` after edge n+DEPTH (DEPTH defaults to 4).
- R3: With `int_align` = 0 sampled together with the write, `div_int` holds the written `wr_int` right after edge n.
- R4: With `int_align` = 1 sampled together with the write, `div_int` takes the written `wr_int` after edge n+DEPTH, which is the same edge on which `div_frac` changes.
- R5: A write that repeats the current integer value leaves `div_int` unchanged at every cycle, whichever value `int_align` has.
- R6: `load_stb` is high for exactly the cycle that follows an edge on which `div_int` or `div_frac` changed. It is low in every other cycle, including after a write that repeats both current values.
- R7: With `mod_rst_off` = 0 at the write, `mod_rst` is high for the cycle right after edge n.
- R8: With `mod_rst_off` = 1 at the write, that write produces no `mod_rst` pulse.
- R9: Writes on consecutive edges each reach the outputs in write order, one cycle apart, and none is dropped.
- R10: A write with `int_align` = 0 cancels every older integer value still waiting on the aligned path. `div_int` never returns to a value older than one it has already shown.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Divide-value register write, one cycle per write |
| wr_int | input | INT_W | Integer part carried by the write |
| wr_frac | input | FRAC_W | Fractional part carried by the write |
| int_align | input | 1 | 1: delay the integer part to match the fractional pipeline |
| mod_rst_off | input | 1 | 1: suppress the modulator reset for this write |
| div_int | output | INT_W | Integer part presented to the divider |
| div_frac | output | FRAC_W | Fractional part presented to the modulator |
| load_stb | output | 1 | High for the cycle after the divide operands changed |
| mod_rst | output | 1 | Modulator reset pulse |

## Verification
The bench aims at the overlap of writes inside the pipeline window. It sends bursts on consecutive edges: a design that shared one holding register would lose middle values, or show them out of order. It mixes an aligned write followed by a fast write: a design without the cancel rule would let `div_int` jump back to the older aligned value DEPTH cycles later. It also writes values equal to the current ones, to catch a strobe that follows the write rather than the actual change. It toggles the reset-suppress control between writes, to catch a pulse that is issued, or dropped, regardless of that control.

// File: rtl/fracn_align_pkg.sv
package fracn_align_pkg;

    // default geometry of the aligner
    localparam int unsigned DEF_DEPTH  = 4;
    localparam int unsigned DEF_INT_W  = 12;
    localparam int unsigned DEF_FRAC_W = 25;

    // path taken by the integer part of one write
    typedef enum logic {
        INT_FAST    = 1'b0,
        INT_ALIGNED = 1'b1
    } int_path_e;

endpackage

// File: rtl/fracn_stage_line.sv
module fracn_stage_line
    import fracn_align_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned INT_W  = DEF_INT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  int_path_e         push_path_i,
    input  logic [INT_W-1:0]  push_int_i,
    input  logic [FRAC_W-1:0] push_frac_i,
    output logic              tail_vld_o,
    output logic              tail_pend_o,
    output logic [INT_W-1:0]  tail_int_o,
    output logic [FRAC_W-1:0] tail_frac_o
);

    localparam int unsigned LAST = DEPTH - 1;

    typedef struct packed {
        logic              vld;   // slot carries a write
        logic              pend;  // integer part still to be applied
        logic [INT_W-1:0]  iv;
        logic [FRAC_W-1:0] fv;
    } slot_t;

    slot_t line_d [DEPTH];
    slot_t line_q [DEPTH];
    logic  cancel;

    // a fast-path write supersedes every older integer still in flight
    assign cancel = push_i && (push_path_i == INT_FAST);

    always_comb begin
        line_d[0].vld  = push_i;
        line_d[0].pend = push_i && (push_path_i == INT_ALIGNED);
        line_d[0].iv   = push_int_i;
        line_d[0].fv   = push_frac_i;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_shift
        always_comb begin
            line_d[k] = line_q[k-1];
            if (cancel) begin
                line_d[k].pend = 1'b0;
            end
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line_q[k] <= '0;
            end else begin
                line_q[k] <= line_d[k];
            end
        end
    end

    assign tail_vld_o  = line_q[LAST].vld;
    assign tail_pend_o = line_q[LAST].pend;
    assign tail_int_o  = line_q[LAST].iv;
    assign tail_frac_o = line_q[LAST].fv;

endmodule

// File: rtl/fracn_out_stage.sv
module fracn_out_stage
    import fracn_align_pkg::*;
#(
    parameter int unsigned INT_W  = DEF_INT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_i,
    input  logic [INT_W-1:0]  fast_int_i,
    input  logic              tail_vld_i,
    input  logic              tail_pend_i,
    input  logic [INT_W-1:0]  tail_int_i,
    input  logic [FRAC_W-1:0] tail_frac_i,
    output logic [INT_W-1:0]  div_int_o,
    output logic [FRAC_W-1:0] div_frac_o,
    output logic              load_stb_o
);

    typedef struct packed {
        logic [INT_W-1:0]  iv;
        logic [FRAC_W-1:0] fv;
        logic              stb;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        // aligned integer leaving the delay line
        if (tail_vld_i && tail_pend_i) begin
            out_d.iv = tail_int_i;
        end
        // a fast-path integer is newer than anything in the line
        if (fast_i) begin
            out_d.iv = fast_int_i;
        end
        if (tail_vld_i) begin
            out_d.fv = tail_frac_i;
        end
        out_d.stb = (out_d.iv != out_q.iv) || (out_d.fv != out_q.fv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign div_int_o  = out_q.iv;
    assign div_frac_o = out_q.fv;
    assign load_stb_o = out_q.stb;

endmodule

// File: rtl/fracn_mod_reset.sv
module fracn_mod_reset (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic off_i,
    output logic pulse_o
);

    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = wr_i && !off_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/fracn_update_aligner.sv
module fracn_update_aligner
    import fracn_align_pkg::*;
#(
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned INT_W  = DEF_INT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [INT_W-1:0]  wr_int,
    input  logic [FRAC_W-1:0] wr_frac,
    input  logic              int_align,
    input  logic              mod_rst_off,
    output logic [INT_W-1:0]  div_int,
    output logic [FRAC_W-1:0] div_frac,
    output logic              load_stb,
    output logic              mod_rst
);

    int_path_e         path;
    logic              fast;
    logic              tail_vld;
    logic              tail_pend;
    logic [INT_W-1:0]  tail_int;
    logic [FRAC_W-1:0] tail_frac;

    assign path = int_align ? INT_ALIGNED : INT_FAST;
    assign fast = wr_en && (path == INT_FAST);

    fracn_stage_line #(
        .DEPTH  (DEPTH),
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (wr_en),
        .push_path_i (path),
        .push_int_i  (wr_int),
        .push_frac_i (wr_frac),
        .tail_vld_o  (tail_vld),
        .tail_pend_o (tail_pend),
        .tail_int_o  (tail_int),
        .tail_frac_o (tail_frac)
    );

    fracn_out_stage #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .fast_i      (fast),
        .fast_int_i  (wr_int),
        .tail_vld_i  (tail_vld),
        .tail_pend_i (tail_pend),
        .tail_int_i  (tail_int),
        .tail_frac_i (tail_frac),
        .div_int_o   (div_int),
        .div_frac_o  (div_frac),
        .load_stb_o  (load_stb)
    );

    fracn_mod_reset u_mrst (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en),
        .off_i   (mod_rst_off),
        .pulse_o (mod_rst)
    );

endmodule

// File: rtl/fracn_update_aligner_chk.sv
module fracn_update_aligner_chk #(
    parameter int unsigned INT_W  = 12,
    parameter int unsigned FRAC_W = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [INT_W-1:0]  wr_int,
    input logic              int_align,
    input logic              mod_rst_off,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic              load_stb,
    input logic              mod_rst
);

    // counts edges since reset, saturating at 2, so $past is only used on post-reset history
    logic [1:0] age_q;
    logic       live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign live = (age_q == 2'd2);

    p_fast_int_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !int_align) |=> (div_int == $past(wr_int)));

    p_strobe_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (load_stb == ((div_int != $past(div_int)) || (div_frac != $past(div_frac)))));

    p_mod_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (mod_rst == $past(wr_en && !mod_rst_off)));

    p_mod_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(mod_rst_off)) |-> !mod_rst);

endmodule

bind fracn_update_aligner fracn_update_aligner_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_int      (wr_int),
    .int_align   (int_align),
    .mod_rst_off (mod_rst_off),
    .div_int     (div_int),
    .div_frac    (div_frac),
    .load_stb    (load_stb),
    .mod_rst     (mod_rst)
);

// File: tb/tb_fracn_update_aligner.sv
module tb_fracn_update_aligner;

    localparam int DEPTH  = 4;
    localparam int INT_W  = 12;
    localparam int FRAC_W = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [INT_W-1:0]  wr_int = '0;
    logic [FRAC_W-1:0] wr_frac = '0;
    logic              int_align = 1'b0;
    logic              mod_rst_off = 1'b0;
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic              load_stb;
    logic              mod_rst;

    fracn_update_aligner #(.DEPTH(DEPTH), .INT_W(INT_W), .FRAC_W(FRAC_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_int(wr_int), .wr_frac(wr_frac),
        .int_align(int_align), .mod_rst_off(mod_rst_off), .div_int(div_int),
        .div_frac(div_frac), .load_stb(load_stb), .mod_rst(mod_rst)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        bit          is_int;
        int          seq;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    mrst_q[$];
    int    seq_ctr = 0;
    int    last_int_seq = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;

    logic [31:0] exp_i = '0;
    logic [31:0] exp_f = '0;
    string       tag_i = "R1";
    string       tag_f = "R1";

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // driver: one write per call, expected items go to the scoreboard
    task automatic do_write(input int iv, input int fv, input bit align, input bit off, input string req);
        item_t it;
        @(negedge clk);
        wr_en = 1'b1; wr_int = INT_W'(iv); wr_frac = FRAC_W'(fv);
        int_align = align; mod_rst_off = off;
        seq_ctr++;
        it.seq = seq_ctr; it.is_int = 1'b1; it.val = 32'(INT_W'(iv)); it.tag = req;
        it.due = align ? cyc + 1 + DEPTH : cyc + 1;
        exp_q.push_back(it);
        it.is_int = 1'b0; it.val = 32'(FRAC_W'(fv)); it.due = cyc + 1 + DEPTH;
        it.tag = (req == "R3") ? "R2" : req;
        exp_q.push_back(it);
        if (!off) mrst_q.push_back(cyc + 1);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            mod_rst_off = 1'b0;
        end
    endtask

    // monitor: retire due items and compare every cycle
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            logic [31:0] pi, pf;
            bit exp_m;
            pi = exp_i; pf = exp_f;
            foreach (exp_q[k]) begin
                if (exp_q[k].due == cyc) begin
                    if (exp_q[k].is_int) begin
                        if (exp_q[k].seq > last_int_seq) begin   // R10: older integers are stale
                            last_int_seq = exp_q[k].seq;
                            exp_i = exp_q[k].val;
                            tag_i = exp_q[k].tag;
                        end
                    end else begin
                        exp_f = exp_q[k].val;
                        tag_f = exp_q[k].tag;
                    end
                end
            end
            for (int k = exp_q.size() - 1; k >= 0; k--) begin
                if (exp_q[k].due <= cyc) exp_q.delete(k);
            end
            exp_m = 1'b0;
            foreach (mrst_q[k]) if (mrst_q[k] == cyc) exp_m = 1'b1;
            for (int k = mrst_q.size() - 1; k >= 0; k--) begin
                if (mrst_q[k] <= cyc) mrst_q.delete(k);
            end
            check(tag_i, "div_int", 32'(div_int), exp_i);
            check(tag_f, "div_frac", 32'(div_frac), exp_f);
            check("R6", "load_stb", 32'(load_stb), 32'((exp_i != pi) || (exp_f != pf)));
            check(exp_m ? "R7" : "R8", "mod_rst", 32'(mod_rst), 32'(exp_m));
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, during and right after reset
        check("R1", "div_int in reset", 32'(div_int), 0);
        check("R1", "div_frac in reset", 32'(div_frac), 0);
        check("R1", "load_stb in reset", 32'(load_stb), 0);
        check("R1", "mod_rst in reset", 32'(mod_rst), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "div_int after reset", 32'(div_int), 0);
        check("R1", "mod_rst after reset", 32'(mod_rst), 0);
        mon_on = 1'b1;

        do_write(5, 'h1000, 1'b0, 1'b0, "R3");        idle(DEPTH + 3);
        do_write(9, 'h2000, 1'b1, 1'b0, "R4");        idle(DEPTH + 3);
        do_write(9, 'h3333, 1'b0, 1'b0, "R5");        idle(DEPTH + 3);
        do_write(9, 'h4444, 1'b1, 1'b0, "R5");        idle(DEPTH + 3);
        do_write(9, 'h4444, 1'b0, 1'b0, "R6");        idle(DEPTH + 3);
        do_write(12, 'h55, 1'b1, 1'b1, "R8");         idle(DEPTH + 3);
        do_write(13, 'h56, 1'b0, 1'b1, "R8");         idle(DEPTH + 3);
        for (int k = 0; k < 6; k++) do_write(20 + k, 'h100 * k + 7, 1'b1, 1'b0, "R9");
        idle(DEPTH + 3);
        for (int k = 0; k < 5; k++) do_write(60 + k, 'h900 + k, 1'b0, k[0], "R9");
        idle(DEPTH + 3);
        do_write(40, 'h111, 1'b1, 1'b0, "R10");
        do_write(41, 'h222, 1'b1, 1'b0, "R10");
        do_write(42, 'h333, 1'b0, 1'b0, "R10");
        idle(DEPTH + 3);
        do_write(70, 'h777, 1'b1, 1'b0, "R10");
        idle(2);
        do_write(71, 'h778, 1'b0, 1'b0, "R10");
        idle(DEPTH + 4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule